// File: doc/BRIEF.md
# Oversampled Programmable UART Receiver

This block turns an asynchronous serial line into parallel words. The receive clock runs at 16 times the bit rate, so one serial bit spans 16 clock cycles. The line is resynchronised, and a falling edge starts a frame. The start bit is checked again half a bit later, and every following bit is sampled in the middle of its cell. The receiver assembles 5 to 8 data bits, least significant first. It then checks an optional parity bit and the first stop bit.

When a frame completes, the word moves into a holding register and a data-available flag rises. Parity, framing and overrun errors appear as separate flags. The host clears data-available with a read strobe or with a separate clear strobe. Word length, parity enable and parity sense are inputs. They are captured when each frame starts, so the host may change them at any time. A synchronous master reset empties the holding register, clears every flag and returns the receiver to idle.

Top module: `serial_word_rx`

## Requirements
- R1: One serial bit lasts OS_RATE (16) clock cycles. A low level seen on the idle line starts a frame, and each later bit is sampled one full bit time after the previous sample point, starting from the middle of the start bit.
- R2: If the line is high again at the midpoint of the start bit (a low pulse shorter than half a bit), the receiver returns to idle, loads no word and leaves data_o and all flags unchanged.
- R3: cfg_wlen_i selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits arrive least significant first and sit right-aligned in data_o. Bits above the word length read as 0.
- R4: With cfg_par_en_i=1, one parity bit follows the data. With cfg_par_odd_i=0 the data bits plus the parity bit must hold an even number of ones; with 1, an odd number. pe_o is set when this fails. With cfg_par_en_i=0 there is no parity bit and pe_o is 0.
- R5: fe_o is 1 when the first stop bit is sampled low, and 0 when it is sampled high.
- R6: The word is loaded and da_o rises inside the stop-bit cell, before that cell ends. Between loads, data_o, pe_o and fe_o hold their values.
- R7: A one-cycle pulse on rd_i or on da_clr_i clears da_o on the next clock edge.
- R8: Each load updates pe_o, fe_o and oe_o. oe_o is 1 when da_o was still set at the moment of the load, and 0 otherwise.
- R9: srst_i clears data_o, da_o, pe_o, fe_o and oe_o and aborts any frame in progress. The next frame is received normally.
- R10: The configuration is captured at start detection. Changes to it during a frame do not affect that frame.
- R11: After rst_ni is released, data_o is 0 and every flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock at OS_RATE times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous master reset |
| rx_i | input | 1 | Serial line, high when idle |
| cfg_wlen_i | input | WLEN_W | Word length code (0 = MIN_W bits) |
| cfg_par_en_i | input | 1 | Parity bit present and checked |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rd_i | input | 1 | Holding-register read strobe, clears data-available |
| da_clr_i | input | 1 | Dedicated data-available clear strobe |
| data_o | output | DATA_W | Holding register, right-aligned word |
| da_o | output | 1 | Data available |
| pe_o | output | 1 | Parity error of the last loaded word |
| fe_o | output | 1 | Framing error of the last loaded word |
| oe_o | output | 1 | Overrun on the last load |

## Verification
The bench builds the block with its defaults: DATA_W=8, MIN_W=5, OS_RATE=16 and SYNC_STAGES=2. This gives the full range of word-length codes, and each bit spans 16 cycles, so the two-stage synchroniser delay sits well inside the half-bit margin. Random frames mix every word length, both parity senses, parity on and off, corrupted parity and stop bits, and random read or clear strobes, which brings both overrun and clean loads within reach. Directed cases add a short start glitch, a configuration change in the middle of a frame and a master reset during a frame.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam int unsigned DEF_DATA_W  = 8;
  localparam int unsigned DEF_MIN_W   = 5;
  localparam int unsigned DEF_OS_RATE = 16;
  localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/swr_framer.sv
module swr_framer
  import swr_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MIN_W   = 5,
  parameter int unsigned OS_RATE = 16,
  parameter int unsigned WLEN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              rx_i,
  input  logic [WLEN_W-1:0] cfg_wlen_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  output logic              load_o,
  output logic [DATA_W-1:0] word_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int unsigned CNT_W = $clog2(OS_RATE);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam int unsigned SPAN  = DATA_W - MIN_W;
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OS_RATE - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bitn_q;
  logic [DATA_W-1:0] sh_q;
  logic [WLEN_W-1:0] wlen_q;
  logic              par_en_q, par_odd_q, pbit_q;

  logic [DATA_W-1:0] aligned;
  logic              last_bit;
  int unsigned       shamt;

  always_comb begin
    shamt    = SPAN - int'(wlen_q);
    aligned  = sh_q >> shamt;
    last_bit = (int'(bitn_q) == int'(MIN_W) - 1 + int'(wlen_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bitn_q    <= '0;
      sh_q      <= '0;
      wlen_q    <= '0;
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
      pbit_q    <= 1'b0;
      load_o    <= 1'b0;
      word_o    <= '0;
      perr_o    <= 1'b0;
      ferr_o    <= 1'b0;
    end else if (srst_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      load_o  <= 1'b0;
    end else begin
      load_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (!rx_i) begin
            state_q   <= ST_START;
            cnt_q     <= '0;
            sh_q      <= '0;
            bitn_q    <= '0;
            // config frozen for the whole frame
            wlen_q    <= cfg_wlen_i;
            par_en_q  <= cfg_par_en_i;
            par_odd_q <= cfg_par_odd_i;
          end
        end
        ST_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_q   <= '0;
            state_q <= rx_i ? ST_IDLE : ST_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == CNT_FULL) begin
            cnt_q <= '0;
            sh_q  <= {rx_i, sh_q[DATA_W-1:1]};
            if (last_bit) state_q <= par_en_q ? ST_PAR : ST_STOP;
            else          bitn_q  <= bitn_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt_q == CNT_FULL) begin
            cnt_q   <= '0;
            pbit_q  <= rx_i;
            state_q <= ST_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == CNT_FULL) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
            load_o  <= 1'b1;
            word_o  <= aligned;
            perr_o  <= par_en_q & (^aligned ^ pbit_q ^ par_odd_q);
            ferr_o  <= ~rx_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swr_hold.sv
module swr_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              rd_i,
  input  logic              da_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              da_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      da_o   <= 1'b0;
      pe_o   <= 1'b0;
      fe_o   <= 1'b0;
      oe_o   <= 1'b0;
    end else if (srst_i) begin
      data_o <= '0;
      da_o   <= 1'b0;
      pe_o   <= 1'b0;
      fe_o   <= 1'b0;
      oe_o   <= 1'b0;
    end else if (load_i) begin
      // a new word wins over a same-cycle clear
      data_o <= word_i;
      pe_o   <= perr_i;
      fe_o   <= ferr_i;
      oe_o   <= da_o;
      da_o   <= 1'b1;
    end else if (rd_i || da_clr_i) begin
      da_o <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import swr_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned MIN_W       = DEF_MIN_W,
  parameter int unsigned OS_RATE     = DEF_OS_RATE,
  parameter int unsigned SYNC_STAGES = DEF_SYNC,
  localparam int unsigned WLEN_W     = $clog2(DATA_W - MIN_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              rx_i,
  input  logic [WLEN_W-1:0] cfg_wlen_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              rd_i,
  input  logic              da_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              da_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              oe_o
);
  logic              rx_s;
  logic              load;
  logic [DATA_W-1:0] word;
  logic              perr, ferr;

  swr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  swr_framer #(
    .DATA_W (DATA_W),
    .MIN_W  (MIN_W),
    .OS_RATE(OS_RATE),
    .WLEN_W (WLEN_W)
  ) u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .srst_i       (srst_i),
    .rx_i         (rx_s),
    .cfg_wlen_i   (cfg_wlen_i),
    .cfg_par_en_i (cfg_par_en_i),
    .cfg_par_odd_i(cfg_par_odd_i),
    .load_o       (load),
    .word_o       (word),
    .perr_o       (perr),
    .ferr_o       (ferr)
  );

  swr_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst_i),
    .load_i  (load),
    .word_i  (word),
    .perr_i  (perr),
    .ferr_i  (ferr),
    .rd_i    (rd_i),
    .da_clr_i(da_clr_i),
    .data_o  (data_o),
    .da_o    (da_o),
    .pe_o    (pe_o),
    .fe_o    (fe_o),
    .oe_o    (oe_o)
  );
endmodule

// File: rtl/swr_checker.sv
module swr_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              srst_i,
  input logic              rd_i,
  input logic              da_clr_i,
  input logic              load_i,
  input logic [DATA_W-1:0] data_o,
  input logic              da_o,
  input logic              pe_o,
  input logic              fe_o,
  input logic              oe_o
);
  AST_LOAD_SETS_DA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !srst_i |=> da_o); // R6

  AST_OVERRUN_ON_UNREAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !srst_i && da_o |=> oe_o); // R8

  AST_NO_OVERRUN_WHEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !srst_i && !da_o |=> !oe_o); // R8

  AST_STROBE_CLEARS_DA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || da_clr_i) && !load_i && !srst_i |=> !da_o); // R7

  AST_SRST_CLEARS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !da_o && !oe_o && !pe_o && !fe_o && (data_o == '0)); // R9

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !srst_i |=> $stable(data_o) && $stable(pe_o) && $stable(fe_o)); // R6
endmodule

bind serial_word_rx swr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .srst_i  (srst_i),
  .rd_i    (rd_i),
  .da_clr_i(da_clr_i),
  .load_i  (load),
  .data_o  (data_o),
  .da_o    (da_o),
  .pe_o    (pe_o),
  .fe_o    (fe_o),
  .oe_o    (oe_o)
);

// File: tb/serial_word_rx_tb.sv
module serial_word_rx_tb;
  localparam int unsigned OSR = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       srst_i = 1'b0;
  logic       rx_i = 1'b1;
  logic [1:0] cfg_wlen_i = 2'd3;
  logic       cfg_par_en_i = 1'b0;
  logic       cfg_par_odd_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       da_clr_i = 1'b0;
  logic [7:0] data_o;
  logic       da_o, pe_o, fe_o, oe_o;

  int n_chk = 0;
  int n_fail = 0;

  // bench model of the holding side
  logic [7:0] m_data = '0;
  logic       m_da = 0, m_pe = 0, m_fe = 0, m_oe = 0;

  always #5 clk = ~clk;

  serial_word_rx u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .srst_i       (srst_i),
    .rx_i         (rx_i),
    .cfg_wlen_i   (cfg_wlen_i),
    .cfg_par_en_i (cfg_par_en_i),
    .cfg_par_odd_i(cfg_par_odd_i),
    .rd_i         (rd_i),
    .da_clr_i     (da_clr_i),
    .data_o       (data_o),
    .da_o         (da_o),
    .pe_o         (pe_o),
    .fe_o         (fe_o),
    .oe_o         (oe_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " data"}, 32'(data_o), 32'(m_data));
    chk({req, " da"},   32'(da_o),   32'(m_da));
    chk({req, " pe"},   32'(pe_o),   32'(m_pe));
    chk({req, " fe"},   32'(fe_o),   32'(m_fe));
    chk({req, " oe"},   32'(oe_o),   32'(m_oe));
  endtask

  task automatic bit_cell(input logic v);
    rx_i = v;
    repeat (OSR) @(negedge clk);
  endtask

  function automatic logic [7:0] wmask(input int wl);
    return 8'((1 << wl) - 1);
  endfunction

  // flip: scramble the config right after the start cell (R10)
  task automatic send_frame(input logic [7:0] d, input int wl, input logic pen,
                            input logic podd, input logic bad_par, input logic bad_stop,
                            input logic flip, input string req);
    logic [7:0] w;
    logic       p;
    w = d & wmask(wl);
    cfg_wlen_i    = 2'(wl - 5);
    cfg_par_en_i  = pen;
    cfg_par_odd_i = podd;
    bit_cell(1'b0);
    if (flip) begin
      cfg_wlen_i    = ~cfg_wlen_i;
      cfg_par_en_i  = ~pen;
      cfg_par_odd_i = ~podd;
    end
    for (int i = 0; i < wl; i++) bit_cell(w[i]);
    if (pen) begin
      p = ^w ^ podd;
      if (bad_par) p = ~p;
      bit_cell(p);
    end
    // R6: nothing loaded before the stop cell
    if (!m_da) chk({req, " R6 da before stop"}, 32'(da_o), 32'd0);
    bit_cell(~bad_stop);
    rx_i = 1'b1;
    m_oe   = m_da;
    m_da   = 1'b1;
    m_data = w;
    m_pe   = pen & bad_par;
    m_fe   = bad_stop;
    check_all(req);
    repeat (bad_stop ? 24 : 8) @(negedge clk);
  endtask

  task automatic strobe_read(input logic use_clr, input string req);
    if (use_clr) da_clr_i = 1'b1; else rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    da_clr_i = 1'b0;
    m_da = 1'b0;
    chk({req, " R7 da cleared"}, 32'(da_o), 32'd0);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1854_5eed);
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R11 reset");

    // R1/R3: 8-bit, no parity
    send_frame(8'hA5, 8, 0, 0, 0, 0, 0, "R1 8bit");
    strobe_read(0, "R7 rd");
    // R3: upper bits zero at 5 bits
    send_frame(8'hFF, 5, 0, 0, 0, 0, 0, "R3 5bit");
    strobe_read(1, "R7 clr");
    // R4 even and odd, good and bad
    send_frame(8'h3C, 7, 1, 0, 0, 0, 0, "R4 even ok");
    strobe_read(0, "R4");
    send_frame(8'h3C, 7, 1, 1, 1, 0, 0, "R4 odd bad");
    strobe_read(0, "R4");
    send_frame(8'h15, 6, 1, 0, 1, 0, 0, "R4 even bad");
    strobe_read(0, "R4");
    // R5 framing
    send_frame(8'h81, 8, 0, 0, 0, 1, 0, "R5 stop low");
    strobe_read(0, "R5");
    // R8 overrun then clean load
    send_frame(8'h12, 8, 0, 0, 0, 0, 0, "R8 first");
    send_frame(8'h34, 8, 0, 0, 0, 0, 0, "R8 overrun");
    strobe_read(0, "R8");
    send_frame(8'h56, 8, 1, 1, 0, 0, 0, "R8 clean");
    strobe_read(1, "R8");
    // R2 glitch shorter than half a bit
    rx_i = 1'b0;
    repeat (5) @(negedge clk);
    rx_i = 1'b1;
    repeat (40) @(negedge clk);
    check_all("R2 glitch");
    // R10 config flipped mid-frame
    send_frame(8'hC3, 8, 0, 0, 0, 0, 1, "R10 flip");
    send_frame(8'h0B, 5, 1, 1, 0, 0, 1, "R10 flip par");
    strobe_read(0, "R10");
    // R9 master reset mid-frame with a word pending
    send_frame(8'h77, 8, 0, 0, 0, 0, 0, "R9 preload");
    rx_i = 1'b0;
    repeat (OSR * 3) @(negedge clk);
    srst_i = 1'b1;
    rx_i = 1'b1;
    @(negedge clk);
    srst_i = 1'b0;
    m_data = '0; m_da = 0; m_pe = 0; m_fe = 0; m_oe = 0;
    check_all("R9 srst");
    repeat (40) @(negedge clk);
    check_all("R9 idle");
    send_frame(8'h9E, 8, 1, 0, 0, 0, 0, "R9 after");
    strobe_read(0, "R9");

    // random frames
    for (int k = 0; k < 48; k++) begin
      logic [7:0] d;
      int         wl, act;
      logic       pen, podd, bp, bs;
      d    = 8'($urandom);
      wl   = 5 + int'($urandom % 4);
      pen  = 1'($urandom);
      podd = 1'($urandom);
      bp   = pen && ($urandom % 4 == 0);
      bs   = ($urandom % 6 == 0);
      send_frame(d, wl, pen, podd, bp, bs, 1'($urandom % 5 == 0), "R1 R3 R4 R5 R8 random");
      act = int'($urandom % 3);
      if (act == 0) strobe_read(0, "R7 random");
      else if (act == 1) strobe_read(1, "R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule